// File: doc/BRIEF.md
# Dual DMA Event Queue Arbiter

This block sits between event prioritization and transfer-request submission in a DMA channel controller. Each incoming event carries an event number, a trigger type and a target queue. Arrival sets a per-event pending bit and records the type and target queue for that event. Each cycle a scanner picks the lowest-numbered pending event whose target queue has room. It writes that event at the tail of its queue and clears the pending bit. An event whose queue is full is never lost. It waits in the pending register until a slot frees.

There are two independent 16-entry FIFO queues, and each feeds its own downstream transfer controller. A fixed-priority selector issues at most one dequeue per cycle. Queue 0 wins whenever both queues hold entries and both controllers are ready. A dequeue drives a one-cycle valid pulse with the entry on that queue's output port. Every queue entry can be read back through a read-only port, addressed relative to the queue head. Occupancy, empty and full flags are exported for each queue.

Top module: `dual_evq_arb`

## Requirements
- R1: There are two queues, each exactly 16 entries deep. An entry is 8 bits wide. Bits [5:0] hold the event number and bits [7:6] hold the trigger type: 00 = event, 01 = manual, 10 = chained, 11 = autotriggered.
- R2: When `evt_vld_i` is high at a clock edge, the pending bit of `evt_num_i` is set and its type and target queue are recorded. On the next edge, the lowest-numbered pending event whose target queue is not full is written at that queue's tail. At most one event is enqueued per cycle.
- R3: An event whose target queue is full stays pending and is not dropped. It enters the queue once a slot frees.
- R4: Each queue delivers its entries in strictly first-in first-out order.
- R5: A queue is dequeued only at an edge where it is non-empty and its `q_rdy_i` bit is high. The entry then appears on `deq_data_o` with `deq_vld_o` high for exactly one cycle after that edge.
- R6: At most one dequeue is issued per cycle. When both queues are non-empty and both ready bits are high, queue 0 is dequeued.
- R7: A pending bit clears in the cycle its event is enqueued. If the same event arrives in that same cycle, the bit stays set and the event is enqueued a second time later.
- R8: `q_cnt_o` gives each queue's occupancy (0 to 16). `q_empty_o` is high at 0 and `q_full_o` is high at 16.
- R9: `rd_data_o` returns entry `rd_idx_i` of queue `rd_q_i`, counted from the head (index 0 is the head). It returns 0 when the index is at or beyond the occupancy. There is no write path into the entries.
- R10: While `rst_ni` is low, all queues are empty, all pending bits are clear and no valid pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_vld_i | input | 1 | Prioritized event present |
| evt_num_i | input | 6 | Event number |
| evt_type_i | input | 2 | Trigger type code |
| evt_q_i | input | 1 | Target queue |
| q_rdy_i | input | 2 | Per-queue consumer ready |
| deq_vld_o | output | 2 | Per-queue dequeue valid pulse |
| deq_data_o | output | 2x8 | Per-queue dequeued entry |
| q_cnt_o | output | 2x5 | Per-queue occupancy |
| q_empty_o | output | 2 | Per-queue empty flag |
| q_full_o | output | 2 | Per-queue full flag |
| rd_q_i | input | 1 | Readback queue select |
| rd_idx_i | input | 4 | Readback entry index from head |
| rd_data_o | output | 8 | Readback entry |

## Verification
The main function is exercised with four input patterns. Streaming events to alternating queues with both consumers ready checks per-queue FIFO ordering without backlog. Sending 18 events to one stalled queue overfills it and shows that the excess events are held pending, not dropped. Loading both queues while stalled and then releasing both consumers together separates fixed priority from round-robin or arrival order. Re-sending an event in the cycle it is enqueued tells "set wins" apart from "clear wins" through the count of queued copies.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TRG_W = 2;
  typedef enum logic [TRG_W-1:0] {
    TRG_EVENT  = 2'b00,
    TRG_MANUAL = 2'b01,
    TRG_CHAIN  = 2'b10,
    TRG_AUTO   = 2'b11
  } trg_e;
endpackage

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o,
  input  logic [PW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] rb_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_data_i;
  end

  assign head_o    = mem[rd_ptr_q];
  assign cnt_o     = cnt_q;
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign rb_addr   = rd_ptr_q + rb_idx_i;
  assign rb_data_o = (CW'(rb_idx_i) < cnt_q) ? mem[rb_addr] : '0;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(cnt_o));
  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
endmodule

// File: rtl/evq_pend.sv
module evq_pend #(
  parameter int NUM_EVT = 64,
  parameter int NUM_Q   = 2,
  parameter int TW      = 2,
  localparam int EW     = $clog2(NUM_EVT),
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [EW-1:0]    set_num_i,
  input  logic [TW-1:0]    set_type_i,
  input  logic [QW-1:0]    set_q_i,
  input  logic [NUM_Q-1:0] full_i,
  output logic [NUM_Q-1:0] enq_o,
  output logic [TW+EW-1:0] enq_data_o
);
  logic [NUM_EVT-1:0] pend_q;
  logic [TW-1:0]      type_q [NUM_EVT];
  logic [QW-1:0]      tq_q   [NUM_EVT];
  logic               found;
  logic [EW-1:0]      sel;

  // lowest-numbered pending event whose queue has room
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (!found && pend_q[i] && !full_i[tq_q[i]]) begin
        found = 1'b1;
        sel   = EW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int i = 0; i < NUM_EVT; i++) begin
        type_q[i] <= '0;
        tq_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (set_vld_i && set_num_i == EW'(i)) begin
          pend_q[i] <= 1'b1;  // set wins over same-cycle clear
          type_q[i] <= set_type_i;
          tq_q[i]   <= set_q_i;
        end else if (found && sel == EW'(i)) begin
          pend_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) enq_o[q] = found && (tq_q[sel] == QW'(q));
  end
  assign enq_data_o = {type_q[sel], sel};

  assert_one_enq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(enq_o));
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vld_i && found && set_num_i == sel) |=> pend_q[$past(set_num_i)]);
  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i |=> pend_q[$past(set_num_i)]);
endmodule

// File: rtl/evq_arb.sv
module evq_arb #(
  parameter int NUM_Q = 2
) (
  input  logic [NUM_Q-1:0] empty_i,
  input  logic [NUM_Q-1:0] rdy_i,
  output logic [NUM_Q-1:0] pop_o
);
  logic taken;
  // fixed priority: lowest queue index wins
  always_comb begin
    taken = 1'b0;
    pop_o = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (!taken && !empty_i[q] && rdy_i[q]) begin
        pop_o[q] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_evq_arb.sv
module dual_evq_arb #(
  parameter int NUM_EVT = 64,
  parameter int NUM_Q   = 2,
  parameter int DEPTH   = 16,
  localparam int EW     = $clog2(NUM_EVT),
  localparam int TW     = evq_pkg::TRG_W,
  localparam int DW     = EW + TW,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      evt_vld_i,
  input  logic [EW-1:0]             evt_num_i,
  input  logic [TW-1:0]             evt_type_i,
  input  logic [QW-1:0]             evt_q_i,
  input  logic [NUM_Q-1:0]          q_rdy_i,
  output logic [NUM_Q-1:0]          deq_vld_o,
  output logic [NUM_Q-1:0][DW-1:0]  deq_data_o,
  output logic [NUM_Q-1:0][CW-1:0]  q_cnt_o,
  output logic [NUM_Q-1:0]          q_empty_o,
  output logic [NUM_Q-1:0]          q_full_o,
  input  logic [QW-1:0]             rd_q_i,
  input  logic [PW-1:0]             rd_idx_i,
  output logic [DW-1:0]             rd_data_o
);
  logic [NUM_Q-1:0]         enq, pop;
  logic [DW-1:0]            enq_data;
  logic [DW-1:0]            head [NUM_Q];
  logic [DW-1:0]            rb   [NUM_Q];
  logic [NUM_Q-1:0]         deq_vld_q;
  logic [NUM_Q-1:0][DW-1:0] deq_data_q;

  evq_pend #(.NUM_EVT(NUM_EVT), .NUM_Q(NUM_Q), .TW(TW)) u_pend (
    .clk_i, .rst_ni,
    .set_vld_i(evt_vld_i), .set_num_i(evt_num_i),
    .set_type_i(evt_type_i), .set_q_i(evt_q_i),
    .full_i(q_full_o), .enq_o(enq), .enq_data_o(enq_data)
  );

  evq_arb #(.NUM_Q(NUM_Q)) u_arb (
    .empty_i(q_empty_o), .rdy_i(q_rdy_i), .pop_o(pop)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    evq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(enq[q]), .push_data_i(enq_data),
      .pop_i(pop[q]), .head_o(head[q]),
      .cnt_o(q_cnt_o[q]), .empty_o(q_empty_o[q]), .full_o(q_full_o[q]),
      .rb_idx_i(rd_idx_i), .rb_data_o(rb[q])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        deq_vld_q[q]  <= 1'b0;
        deq_data_q[q] <= '0;
      end else begin
        deq_vld_q[q] <= pop[q];
        if (pop[q]) deq_data_q[q] <= head[q];
      end
    end

    assert_deq_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deq_vld_o[q] |-> $past(q_rdy_i[q] && !q_empty_o[q]));
  end

  assign deq_vld_o  = deq_vld_q;
  assign deq_data_o = deq_data_q;
  assign rd_data_o  = rb[rd_q_i];

  assert_one_deq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(deq_vld_o));
  assert_q0_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_vld_o[1] |-> !$past(q_rdy_i[0] && !q_empty_o[0]));
  assert_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q_empty_o[0] && q_full_o[0]) && !(q_empty_o[1] && q_full_o[1]));
endmodule

// File: tb/sim_dual_evq_arb.sv
`timescale 1ns/1ps
module sim_dual_evq_arb;
  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           evt_vld_i = 1'b0;
  logic [5:0]     evt_num_i = '0;
  logic [1:0]     evt_type_i = '0;
  logic           evt_q_i = 1'b0;
  logic [1:0]     q_rdy_i = '0;
  logic [1:0]     deq_vld_o;
  logic [1:0][7:0] deq_data_o;
  logic [1:0][4:0] q_cnt_o;
  logic [1:0]     q_empty_o, q_full_o;
  logic           rd_q_i = 1'b0;
  logic [3:0]     rd_idx_i = '0;
  logic [7:0]     rd_data_o;

  int tests = 0, fails = 0;
  bit mon_en = 1'b0;
  logic [7:0] sb0 [$];
  logic [7:0] sb1 [$];

  always #2.5 clk = ~clk;

  dual_evq_arb u0 (
    .clk_i(clk), .rst_ni, .evt_vld_i, .evt_num_i, .evt_type_i, .evt_q_i,
    .q_rdy_i, .deq_vld_o, .deq_data_o, .q_cnt_o, .q_empty_o, .q_full_o,
    .rd_q_i, .rd_idx_i, .rd_data_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one event per call, expected entry goes to that queue's scoreboard
  task automatic send(logic [5:0] num, logic [1:0] typ, logic q);
    evt_vld_i  = 1'b1;
    evt_num_i  = num;
    evt_type_i = typ;
    evt_q_i    = q;
    if (q) sb1.push_back({typ, num}); else sb0.push_back({typ, num});
    @(negedge clk);
  endtask

  task automatic idle(int n);
    evt_vld_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every dequeue pulse to the scoreboard (R4, R5)
  always @(negedge clk) begin
    if (mon_en) begin
      if (deq_vld_o[0]) begin
        if (sb0.size() == 0) check("R4 q0 unexpected", deq_data_o[0], 32'hFFFF);
        else check("R4 q0 order", deq_data_o[0], sb0.pop_front());
      end
      if (deq_vld_o[1]) begin
        if (sb1.size() == 0) check("R4 q1 unexpected", deq_data_o[1], 32'hFFFF);
        else check("R4 q1 order", deq_data_o[1], sb1.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 empty", q_empty_o, 2'b11);
    check("R10 cnt0", q_cnt_o[0], 0);
    check("R10 vld", deq_vld_o, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    check("R8 empty after reset", q_empty_o, 2'b11);

    // streaming, both ready (R2 R4 R5)
    q_rdy_i = 2'b11;
    for (int i = 0; i < 10; i++) send(6'(50 + i), 2'(i % 4), 1'(i % 2));
    idle(8);
    check("R4 stream sb0 drained", sb0.size(), 0);
    check("R4 stream sb1 drained", sb1.size(), 0);

    // overfill queue 0 while stalled (R1 R3 R8 R9)
    q_rdy_i = 2'b00;
    for (int i = 0; i < 18; i++) send(6'(i), 2'(i % 4), 1'b0);
    idle(4);
    check("R8 cnt0 full", q_cnt_o[0], 16);
    check("R8 full0", q_full_o[0], 1'b1);
    check("R8 empty0", q_empty_o[0], 1'b0);
    check("R3 no deq while stalled", deq_vld_o, 2'b00);
    rd_q_i = 1'b0; rd_idx_i = 4'd5; #0.1;
    check("R9 rb q0 idx5 manual/5", rd_data_o, 8'h45);
    rd_idx_i = 4'd15; #0.1;
    check("R1 rb q0 idx15 auto/15", rd_data_o, 8'hCF);
    rd_idx_i = 4'd0; #0.1;
    check("R9 rb q0 head event/0", rd_data_o, 8'h00);
    q_rdy_i = 2'b01;
    idle(30);
    check("R3 all 18 delivered", sb0.size(), 0);
    check("R8 empty0 drained", q_empty_o[0], 1'b1);

    // priority: both loaded, released together (R6)
    q_rdy_i = 2'b00;
    mon_en = 1'b0;
    for (int i = 0; i < 3; i++) send(6'(20 + i), 2'b01, 1'b0);
    for (int i = 0; i < 3; i++) send(6'(30 + i), 2'b10, 1'b1);
    idle(3);
    check("R8 cnt1 3", q_cnt_o[1], 3);
    q_rdy_i = 2'b11;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k < 3) begin
        check("R6 q0 first vld", deq_vld_o, 2'b01);
        check("R6 q0 first data", deq_data_o[0], {2'b01, 6'(20 + k)});
      end else begin
        check("R6 q1 after vld", deq_vld_o, 2'b10);
        check("R6 q1 after data", deq_data_o[1], {2'b10, 6'(30 + k - 3)});
      end
    end
    sb0.delete(); sb1.delete();
    @(negedge clk);
    check("R5 single-cycle pulse", deq_vld_o, 2'b00);
    mon_en = 1'b1;

    // set and clear in same cycle (R7)
    q_rdy_i = 2'b00;
    send(6'd40, 2'b10, 1'b1);
    send(6'd40, 2'b11, 1'b1);
    idle(4);
    check("R7 two copies queued", q_cnt_o[1], 2);
    rd_q_i = 1'b1; rd_idx_i = 4'd0; #0.1;
    check("R7 first copy chained", rd_data_o, 8'hA8);
    rd_idx_i = 4'd1; #0.1;
    check("R7 second copy auto", rd_data_o, 8'hE8);
    rd_idx_i = 4'd2; #0.1;
    check("R9 beyond occupancy zero", rd_data_o, 8'h00);
    q_rdy_i = 2'b10;
    idle(6);
    check("R7 drained", sb1.size(), 0);
    check("R8 both empty", q_empty_o, 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule